// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Zero Flag

This block is the arithmetic core of a small accumulator machine. Each cycle it combines the held accumulator value with a memory operand under a four-bit operation code, which can select a pass-through, an arithmetic step, a bitwise step, or a single-place shift. The control logic raises a write strobe to commit the result to the accumulator on a rising clock edge.

A registered zero indicator is kept next to the accumulator and is refreshed on every edge that writes it. The combinational result is also brought out, so the control logic can route it elsewhere before committing it. Decoding instructions, accessing memory and producing carry or overflow flags are left to other blocks.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator output is 0 and the zero indicator is 1.
- R2: When the strobe is low on a clock edge, the accumulator and the zero indicator keep their values.
- R3: When the strobe is high, the accumulator takes the result selected by the operation code on that edge: 0 gives A, 1 gives M, 2 gives A+M and 3 gives A-M, both modulo 2^16.
- R4: Code 4 gives A AND M and code 5 gives A OR M.
- R5: Code 6 gives the bitwise complement of A, whatever the value of M.
- R6: Code 7 shifts A left by one place and code 8 shifts it right by one place. The vacated bit is filled with 0 and M has no effect.
- R7: Codes 9 to 15 give A unchanged.
- R8: On every edge that writes the accumulator, the zero indicator becomes 1 if the new accumulator value is 0 and becomes 0 otherwise.
- R9: The result output shows the combinational value for the present accumulator, operand and code, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Strobe that commits the result to the accumulator |
| op_sel | input | 4 | Operation code |
| mem_opnd | input | 16 | Memory operand M |
| acc_q | output | 16 | Accumulator register |
| res_d | output | 16 | Combinational result |
| zero_q | output | 1 | Registered zero indicator |

## Verification
A wrong operation decode shows on the result output in the same cycle, and it reaches the accumulator on the next strobed edge. If the zero indicator drifts away from the accumulator, the error is visible right after the edge that wrote it, because the bench compares both outputs after every edge. The tests also chain operations, so a corrupted accumulator spreads into each later expected value instead of being hidden.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [3:0] {
      OP_PASS_A = 4'd0,
      OP_PASS_M = 4'd1,
      OP_ADD    = 4'd2,
      OP_SUB    = 4'd3,
      OP_AND    = 4'd4,
      OP_OR     = 4'd5,
      OP_INV    = 4'd6,
      OP_SHL    = 4'd7,
      OP_SHR    = 4'd8
   } op_e;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
   parameter int W = 16,
   parameter int OPW = 4
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   m,
   input  logic [OPW-1:0] op,
   output logic [W-1:0]   y
);
   import acc_alu_pkg::*;

   initial begin
      if (W < 2) $error("acc_alu_logic: W must be at least 2");
      if (OPW < 4) $error("acc_alu_logic: OPW must be at least 4");
   end

   logic [W-1:0] sum_v, dif_v;
   assign sum_v = a + m;
   assign dif_v = a - m;

   always_comb begin
      unique case (op)
         OPW'(OP_PASS_M): y = m;
         OPW'(OP_ADD):    y = sum_v;
         OPW'(OP_SUB):    y = dif_v;
         OPW'(OP_AND):    y = a & m;
         OPW'(OP_OR):     y = a | m;
         OPW'(OP_INV):    y = ~a;
         OPW'(OP_SHL):    y = {a[W-2:0], 1'b0};
         OPW'(OP_SHR):    y = {1'b0, a[W-1:1]};
         default:         y = a;
      endcase
   end

   // R5
   inv_ignores_m_chk: assert final (op != OPW'(OP_INV) || y == ~a);
   // R6
   shl_fill_chk: assert final (op != OPW'(OP_SHL) || y[0] == 1'b0);
endmodule

// File: rtl/acc_alu_reg.sv
module acc_alu_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         z
);
   logic d_zero;
   assign d_zero = (d == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
         z <= 1'b1;
      end else if (load) begin
         q <= d;
         z <= d_zero;
      end
   end

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(q) && $stable(z)));
   // R8
   zero_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (z == (q == '0)));
   // R3
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int W = 16,
   parameter int OPW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [OPW-1:0] op_sel,
   input  logic [W-1:0]   mem_opnd,
   output logic [W-1:0]   acc_q,
   output logic [W-1:0]   res_d,
   output logic           zero_q
);
   acc_alu_logic #(.W(W), .OPW(OPW)) u_logic (
      .a(acc_q), .m(mem_opnd), .op(op_sel), .y(res_d)
   );

   acc_alu_reg #(.W(W)) u_reg (
      .clk(clk), .rst_n(rst_n), .load(wr_en), .d(res_d),
      .q(acc_q), .z(zero_q)
   );

   // R1
   rst_state_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (acc_q == '0 && zero_q));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
   logic clk = 0, rst_n = 0, wr_en = 0;
   logic [3:0] op_sel = 0;
   logic [15:0] mem_opnd = 0;
   logic [15:0] acc_q, res_d;
   logic zero_q;
   int checks = 0, errors = 0;
   logic [15:0] model = 0;
   logic [15:0] exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   acc_alu u0 (.*);

   function automatic logic [15:0] f(input logic [3:0] o, input logic [15:0] a, input logic [15:0] m);
      case (o)
         1: return m;
         2: return a + m;
         3: return a - m;
         4: return a & m;
         5: return a | m;
         6: return ~a;
         7: return a << 1;
         8: return a >> 1;
         default: return a;
      endcase
   endfunction

   task automatic chk(input string r, input logic [15:0] act, input logic [15:0] ex);
      checks++;
      if (act !== ex) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", r, act, ex);
      end
   endtask

   task automatic step(input logic we, input logic [3:0] o, input logic [15:0] m, input string r);
      @(negedge clk);
      wr_en = we; op_sel = o; mem_opnd = m;
      #1 chk({r, " comb R9"}, res_d, f(o, model, m));
      if (we) model = f(o, model, m);
      exp_q.push_back(model);
      tag_q.push_back(r);
   endtask

   // monitor: pops expected accumulator after each edge
   initial forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, acc_q, e);
         chk({t, " zero R8"}, {15'd0, zero_q}, {15'd0, e == 0});
      end
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #20;
      chk("R1 acc", acc_q, 0);
      chk("R1 zero", {15'd0, zero_q}, 16'd1);
      @(negedge clk) rst_n = 1;
      step(1, 1, 16'h1234, "R3 passM");
      step(0, 2, 16'h1111, "R2 hold");
      step(1, 0, 16'hFFFF, "R3 passA");
      step(1, 2, 16'hF000, "R3 add");
      step(1, 2, 16'hFFFF, "R3 add wrap");
      step(1, 3, 16'h0233, "R3 sub");
      step(1, 3, 16'h0001, "R3 sub wrap");
      step(1, 4, 16'h0F0F, "R4 and");
      step(1, 5, 16'hA000, "R4 or");
      step(1, 6, 16'h5555, "R5 inv");
      step(1, 6, 16'h0000, "R5 inv");
      step(1, 7, 16'hFFFF, "R6 shl");
      step(1, 8, 16'hFFFF, "R6 shr");
      step(1, 1, 16'h8001, "R6 load");
      step(1, 7, 16'h0000, "R6 shl msb");
      step(1, 8, 16'h1234, "R6 shr");
      for (int c = 9; c < 16; c++) step(1, 4'(c), 16'hDEAD, "R7 undefined");
      step(1, 4, 16'h0000, "R8 zero set");
      step(0, 1, 16'h0005, "R2 hold zero");
      step(1, 1, 16'h0005, "R8 zero clear");
      step(1, 3, 16'h0005, "R8 zero from sub");
      step(1, 8, 16'h0001, "R6 shr zero");
      step(0, 0, 16'h0, "drain");
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule